// File: doc/BRIEF.md
# Bus Mastership Request and Tenure Limiter

This block decides when a local bridge asks for mastership of a shared backplane bus and how long it keeps the bus once it has it. Several agents can start a request. A transmit write queue requests the bus as long as it holds posted writes. A DMA start pulse, a local CPU read, and an interrupt-acknowledge start each post a request. A local CPU write posts a request directly only when the atomic mode bit is set. In decoupled mode the write goes to the queue instead, and the queue's pending flag raises the request.

When an external arbiter grants the bus, the block holds ownership and runs a tenure timer. The timer counts millisecond ticks from an internal prescaler, and both the prescaler and the timer restart on every new grant. The tenure limit can be set to one of these choices:
- release after a single bus cycle
- 2 ms, 4 ms or 8 ms
- unlimited

When the limit is reached, the block flags expiry. It gives the bus up only when no bus cycle is in progress. This bounds the time other masters wait for the bus.

Top module: `bus_tenure_ctrl`

## Requirements
- R1: While the block does not own the bus, `fifo_pend` high drives `bus_req` high in the same cycle, with no register in between.
- R2: A one-cycle pulse on `dma_start`, `cpu_rd` or `iack_go` raises `bus_req` from the cycle after the pulse. The request stays high until the block owns the bus.
- R3: A `cpu_wr` pulse raises `bus_req` from the next cycle only when `atomic_mode` is 1. When `atomic_mode` is 0, `bus_req` stays low after a `cpu_wr` pulse.
- R4: If `bus_grant` and `bus_req` are both high at a clock edge, `bus_owned` is 1 after that edge and `bus_req` is 0 while the block owns the bus.
- R5: Set `limit_sel` to 1, 2 or 3 for a limit L of 2, 4 or 8 ms, where one ms is CLKS_PER_MS clocks. `tenure_expired` is 0 for the first L·CLKS_PER_MS-1 edges after the grant edge and 1 from edge L·CLKS_PER_MS on.
- R6: The block never releases the bus while `cycle_busy` is high. Once the tenure has expired, the first edge with `cycle_busy` low clears `bus_owned`. `bus_release` is then high for exactly that one following cycle.
- R7: With `limit_sel` = 0, `tenure_expired` rises on the first edge during ownership where `cycle_busy` is high. The bus is released once that cycle ends, even if work is still pending.
- R8: With `limit_sel` 4 to 7, `tenure_expired` never rises. The bus is released only at an edge where `cycle_busy`, `fifo_pend` and the posted request are all low.
- R9: Each new grant restarts the tenure timer. After a regrant, `tenure_expired` is 0 and the full limit is counted again.
- R10: After reset, `bus_req`, `bus_owned`, `bus_release` and `tenure_expired` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_pend | input | 1 | Write queue holds posted cycles (level) |
| dma_start | input | 1 | DMA transfer start pulse |
| cpu_rd | input | 1 | CPU read to the bus starts (pulse) |
| cpu_wr | input | 1 | CPU write to the bus starts (pulse) |
| atomic_mode | input | 1 | 1 = atomic CPU writes, 0 = decoupled |
| iack_go | input | 1 | Interrupt-acknowledge cycle start pulse |
| limit_sel | input | 3 | Tenure limit: 0 one cycle, 1 2 ms, 2 4 ms, 3 8 ms, 4-7 unlimited |
| bus_grant | input | 1 | Grant from the external arbiter |
| cycle_busy | input | 1 | A bus cycle is in progress |
| bus_req | output | 1 | Mastership request |
| bus_owned | output | 1 | The block currently holds the bus |
| bus_release | output | 1 | One-cycle pulse after ownership ends |
| tenure_expired | output | 1 | Tenure limit reached while the bus is still owned |

## Verification
Two functions can land in the same cycle: tenure expiry and a bus cycle that is still running. The bench holds `cycle_busy` high across the edge at which the millisecond count reaches its limit. It checks that `tenure_expired` rises at exactly that edge while `bus_owned` stays 1. It then drops `cycle_busy` and checks that release follows on the next edge. The same overlap is forced in single-cycle mode, where expiry is caused by the busy cycle itself and work is still queued.

// File: rtl/bus_tenure_ctrl.sv
module bus_tenure_ctrl #(
  parameter int CLKS_PER_MS = 50000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fifo_pend,
  input  logic       dma_start,
  input  logic       cpu_rd,
  input  logic       cpu_wr,
  input  logic       atomic_mode,
  input  logic       iack_go,
  input  logic [2:0] limit_sel,
  input  logic       bus_grant,
  input  logic       cycle_busy,
  output logic       bus_req,
  output logic       bus_owned,
  output logic       bus_release,
  output logic       tenure_expired
);
  localparam int PW = (CLKS_PER_MS > 1) ? $clog2(CLKS_PER_MS) : 1;
  localparam logic [PW-1:0] PRE_TOP = PW'(CLKS_PER_MS - 1);

  logic          own_q, pend_q, seen_q, rel_q;
  logic [PW-1:0] pre_q;
  logic [3:0]    ms_q;
  logic [3:0]    lim_ms;
  logic          lim_on;

  always_comb begin
    lim_on = 1'b1;
    case (limit_sel)
      3'd1:    lim_ms = 4'd2;
      3'd2:    lim_ms = 4'd4;
      3'd3:    lim_ms = 4'd8;
      default: begin lim_ms = 4'd0; lim_on = 1'b0; end
    endcase
  end

  wire post  = dma_start | cpu_rd | iack_go | (cpu_wr & atomic_mode);
  wire take  = ~own_q & bus_req & bus_grant;
  wire tick  = own_q & (pre_q == PRE_TOP);
  wire expd  = own_q & (((limit_sel == 3'd0) & seen_q) | (lim_on & (ms_q >= lim_ms)));
  wire idle  = ~fifo_pend & ~pend_q;
  wire drop  = own_q & ~cycle_busy & (expd | idle);

  assign bus_req        = ~own_q & (fifo_pend | pend_q);
  assign bus_owned      = own_q;
  assign bus_release    = rel_q;
  assign tenure_expired = expd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      own_q  <= 1'b0;
      pend_q <= 1'b0;
      seen_q <= 1'b0;
      rel_q  <= 1'b0;
      pre_q  <= '0;
      ms_q   <= '0;
    end else begin
      rel_q  <= drop;
      pend_q <= (pend_q & ~(own_q & cycle_busy)) | post;
      if (take)      own_q <= 1'b1;
      else if (drop) own_q <= 1'b0;
      if (take || !own_q || tick) pre_q <= '0;
      else                        pre_q <= pre_q + PW'(1);
      if (take)                         ms_q <= '0;
      else if (tick && ms_q != 4'hf)    ms_q <= ms_q + 4'd1;
      if (take)                         seen_q <= 1'b0;
      else if (own_q && cycle_busy)     seen_q <= 1'b1;
    end
  end

  // R4
  grant_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_owned && bus_req && bus_grant) |=> bus_owned);
  // R6
  no_midcycle_rel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_owned && cycle_busy) |=> bus_owned);
  // R6
  rel_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_release |=> !bus_release);
  // R6
  rel_follows_own_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_owned) |-> bus_release);
  // R2
  post_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_owned && dma_start) |=> (bus_req || bus_owned));
  // R8
  unlimited_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (limit_sel[2] && $stable(limit_sel)) |-> !tenure_expired);
endmodule

// File: tb/sim_bus_tenure_ctrl.sv
module sim_bus_tenure_ctrl;
  localparam int P = 10;
  logic clk = 0, rst_n = 0;
  logic fifo_pend = 0, dma_start = 0, cpu_rd = 0, cpu_wr = 0, atomic_mode = 0, iack_go = 0;
  logic [2:0] limit_sel = 3'd4;
  logic bus_grant = 0, cycle_busy = 0;
  logic bus_req, bus_owned, bus_release, tenure_expired;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  bus_tenure_ctrl #(.CLKS_PER_MS(P)) u0 (
    .clk(clk), .rst_n(rst_n), .fifo_pend(fifo_pend), .dma_start(dma_start),
    .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .atomic_mode(atomic_mode), .iack_go(iack_go),
    .limit_sel(limit_sel), .bus_grant(bus_grant), .cycle_busy(cycle_busy),
    .bus_req(bus_req), .bus_owned(bus_owned), .bus_release(bus_release),
    .tenure_expired(tenure_expired));

  task automatic chk(input logic act, input logic exp, input string req);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic serve(input string req);
    bus_grant = 1; step(); bus_grant = 0;
    chk(bus_owned, 1'b1, req);
    chk(bus_req, 1'b0, "R4");
    cycle_busy = 1; step(); step();
    cycle_busy = 0; step();
    chk(bus_owned, 1'b0, req);
    chk(bus_release, 1'b1, "R6");
    step();
    chk(bus_release, 1'b0, "R6");
  endtask

  task automatic t_reset();
    chk(bus_req, 1'b0, "R10"); chk(bus_owned, 1'b0, "R10");
    chk(bus_release, 1'b0, "R10"); chk(tenure_expired, 1'b0, "R10");
  endtask

  task automatic t_fifo_unlimited();
    limit_sel = 3'd5; fifo_pend = 1; #1;
    chk(bus_req, 1'b1, "R1");
    bus_grant = 1; step(); bus_grant = 0;
    chk(bus_owned, 1'b1, "R4"); chk(bus_req, 1'b0, "R4");
    cycle_busy = 1;
    for (int k = 0; k < 100; k++) begin
      step();
      chk(tenure_expired, 1'b0, "R8");
    end
    cycle_busy = 0; step();
    chk(bus_owned, 1'b1, "R8");
    fifo_pend = 0; step();
    chk(bus_owned, 1'b0, "R8"); chk(bus_release, 1'b1, "R8");
    step();
  endtask

  task automatic t_pulses();
    limit_sel = 3'd4;
    for (int s = 0; s < 3; s++) begin
      if (s == 0) dma_start = 1; else if (s == 1) cpu_rd = 1; else iack_go = 1;
      #1; chk(bus_req, 1'b0, "R2");
      step(); dma_start = 0; cpu_rd = 0; iack_go = 0;
      chk(bus_req, 1'b1, "R2");
      step(); chk(bus_req, 1'b1, "R2");
      serve("R2");
    end
  endtask

  task automatic t_write_mode();
    atomic_mode = 0; cpu_wr = 1; step(); cpu_wr = 0;
    chk(bus_req, 1'b0, "R3");
    step(); chk(bus_req, 1'b0, "R3");
    atomic_mode = 1; cpu_wr = 1; step(); cpu_wr = 0;
    chk(bus_req, 1'b1, "R3");
    serve("R3");
    atomic_mode = 0;
  endtask

  task automatic t_ms(input logic [2:0] sel, input int lim, input bit regrant);
    limit_sel = sel; fifo_pend = 1; #1;
    bus_grant = 1; step(); bus_grant = 0;
    cycle_busy = 1;
    for (int k = 1; k <= lim * P + 3; k++) begin
      step();
      chk(tenure_expired, (k >= lim * P) ? 1'b1 : 1'b0, "R5");
      chk(bus_owned, 1'b1, "R6");
    end
    cycle_busy = 0; step();
    chk(bus_owned, 1'b0, "R6"); chk(bus_release, 1'b1, "R6");
    chk(tenure_expired, 1'b0, "R6");
    if (regrant) begin
      chk(bus_req, 1'b1, "R1");
      bus_grant = 1; step(); bus_grant = 0;
      chk(tenure_expired, 1'b0, "R9");
      for (int k = 1; k <= lim * P; k++) begin
        step();
        chk(tenure_expired, (k >= lim * P) ? 1'b1 : 1'b0, "R9");
      end
      step();
      chk(bus_owned, 1'b0, "R9");
    end
    fifo_pend = 0; step(); step();
  endtask

  task automatic t_single();
    limit_sel = 3'd0; fifo_pend = 1; #1;
    bus_grant = 1; step(); bus_grant = 0;
    chk(tenure_expired, 1'b0, "R7");
    step(); chk(bus_owned, 1'b1, "R7");
    cycle_busy = 1; step();
    chk(tenure_expired, 1'b1, "R7"); chk(bus_owned, 1'b1, "R7");
    step(); chk(bus_owned, 1'b1, "R7");
    cycle_busy = 0; step();
    chk(bus_owned, 1'b0, "R7"); chk(bus_release, 1'b1, "R7");
    fifo_pend = 0; step(); step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) step();
    rst_n = 1; #1;
    t_reset();
    t_fifo_unlimited();
    t_pulses();
    t_write_mode();
    t_ms(3'd1, 2, 1'b1);
    t_ms(3'd2, 4, 1'b0);
    t_ms(3'd3, 8, 1'b0);
    t_single();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule